// File: doc/BRIEF.md
# MDIO Management Command Register

This block drives single clause-22 management transactions toward an Ethernet PHY from one 32-bit host register. The host writes a command word that names the direction, the PHY address, the register address and, for a write, the data. The unit then shifts a complete serial frame out on MDC/MDIO and, for a read, shifts the PHY's answer back into the same register.

Bit 31 of the word is a request flag. It is set by the host to start a frame and reads back as 1 until the frame has finished, then the hardware clears it. The host polls this bit to learn that the transaction is over and, for reads, that bits 15:0 now hold the PHY data. Writes made while the flag is still set are dropped. MDC is produced by dividing the system clock, with the half period given by a parameter.

Top module: `mdio_cmd_reg`

## Requirements
- R1: A host write made while bit 31 reads 0 replaces the whole register, and rd_data returns it. If bit 31 of the written word is 0, no frame starts and MDC stays low.
- R2: The command word uses these fields: bit 30 set to 1 selects a write, and bit 30 at 0 selects a read. Bits 25:21 hold the PHY address, bits 20:16 the register address and bits 15:0 the data. A write frame is 64 bits sent MSB first: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then bits 15:0. For example, word 0xC0A09000 produces 0xFFFFFFFF_52829000.
- R3: A read frame uses opcode 10. mdio_oe is low for the two turnaround bits and the 16 data bits, and high for the first 46 bits.
- R4: During a read, MDIO is sampled on each rising MDC edge of the 16 data bits and shifted MSB first into bits 15:0.
- R5: MDC is low whenever no frame is in progress. During a frame, each bit is one MDC_HALF-cycle low phase followed by one MDC_HALF-cycle high phase.
- R6: Bit 31 stays 1 for exactly 128*MDC_HALF clock cycles after the accepting edge. It clears together with the falling MDC edge that ends the last bit. Bits 30:16 are preserved.
- R7: A host write made while bit 31 is 1 has no effect on the register or on the frame.
- R8: After reset, the register is 0 and MDC, mdio_o and mdio_oe are 0.
- R9: mdio_o and mdio_oe change only when MDC falls or when a frame starts. They are stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the command register |
| wr_data | input | 32 | Command word written by the host |
| rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Serial data from the PHY |

## Verification
The bench runs write frames to two different PHY addresses. It compares the captured 64-bit serial streams, which separates the opcode, address and turnaround fields from each other. Read frames are tried with alternating and single-bit PHY answers at extreme addresses. These show the sampling edge, the bit order and the release of MDIO. Further patterns cover a command with bit 31 clear, a command written in the middle of a frame, and a command issued on the first cycle after completion. They tell a properly gated request flag apart from a leaky one. A behavioural model predicts MDC, MDIO and the register on every cycle.

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg #(
  parameter int MDC_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(MDC_HALF - 1);
  localparam logic [5:0] TA_IDX   = 6'd46;
  localparam logic [5:0] DATA_IDX = 6'd48;
  localparam logic [5:0] LAST_IDX = 6'd63;

  logic [31:0]   cmd;
  logic [DW-1:0] div;
  logic [5:0]    idx;
  logic [63:0]   frame;
  logic          busy, is_wr, tick;

  assign busy  = cmd[31];
  assign is_wr = cmd[30];
  assign tick  = busy && (div == DIV_LAST);
  assign frame = {32'hFFFF_FFFF, 2'b01, (is_wr ? 2'b01 : 2'b10),
                  cmd[25:21], cmd[20:16], 2'b10, cmd[15:0]};

  assign mdio_oe = busy && (is_wr || idx < TA_IDX);
  assign mdio_o  = mdio_oe && frame[LAST_IDX - idx];
  assign rd_data = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0;
      div <= '0;
      idx <= '0;
      mdc <= 1'b0;
    end else if (!busy) begin
      if (wr_en) cmd <= wr_data;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        mdc <= ~mdc;
        if (!mdc) begin
          if (!is_wr && idx >= DATA_IDX) cmd[15:0] <= {cmd[14:0], mdio_i};
        end else if (idx == LAST_IDX) begin
          cmd[31] <= 1'b0;
          idx     <= '0;
        end else begin
          idx <= idx + 6'd1;
        end
      end
    end
  end
endmodule

module mdio_cmd_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |-> (!mdc && !mdio_oe && !mdio_o)); // R5
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && rd_data[30]) |-> mdio_oe); // R2
  AST_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R9
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && wr_en) |=> $stable(rd_data[30:16])); // R7
  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[31]) |-> $fell(mdc)); // R6
  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[31]) && rd_data[31] && !$stable(rd_data[15:0])) |-> $rose(mdc)); // R4
endmodule

bind mdio_cmd_reg mdio_cmd_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_cmd_reg_tb.sv
module mdio_cmd_reg_tb;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [31:0] m_reg = '0;
  bit          m_active = 0;
  int          m_t = 0;
  logic [15:0] phy_val = '0;
  logic [63:0] cap = '0;

  mdio_cmd_reg #(.MDC_HALF(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(logic [31:0] w);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, w[30] ? 2'b01 : 2'b10, w[25:21], w[20:16], 2'b10, w[15:0]};
    return f;
  endfunction

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = '0; m_active = 0; m_t = 0;
    end else if (m_active) begin
      m_t++;
      if ((m_t % (2*H)) == H && (m_t / (2*H)) >= 48 && !m_reg[30])
        m_reg[15:0] = {m_reg[14:0], mdio_i};
      if (m_t == 128*H) begin
        m_reg[31] = 1'b0; m_active = 0;
      end
    end else if (wr_en) begin
      m_reg = wr_data;
      if (wr_data[31]) begin m_active = 1; m_t = 0; end
    end
  end

  always @(posedge mdc) cap = {cap[62:0], mdio_o};

  always @(negedge clk) begin
    int k;
    logic e_mdc, e_oe, e_o;
    k = m_t / (2*H);
    if (m_active && k >= 48) mdio_i = phy_val[15-(k-48)];
    else mdio_i = 1'b1;
    if (rst_n && !done_flag) begin
      if (m_active) begin
        e_mdc = ((m_t / H) % 2) == 1;
        e_oe  = m_reg[30] || k < 46;
        e_o   = e_oe && exp_frame(m_reg)[63-k];
      end else begin
        e_mdc = 0; e_oe = 0; e_o = 0;
      end
      chk("R5 mdc", 64'(mdc), 64'(e_mdc));
      chk("R3 mdio_oe", 64'(mdio_oe), 64'(e_oe));
      chk("R2 mdio_o", 64'(mdio_o), 64'(e_o));
      chk("R6 rd_data", 64'(rd_data), 64'(m_reg));
    end
  end

  task automatic write_cmd(logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (rd_data[31] && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    #45;
    chk("R8 reset rd_data", 64'(rd_data), 64'h0);
    chk("R8 reset mdc/oe/o", {61'h0, mdc, mdio_oe, mdio_o}, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    write_cmd(32'hC0A0_9000);
    wait_done(n);
    chk("R2 write frame PHY5", cap, 64'hFFFF_FFFF_5282_9000);
    chk("R6 busy length", 64'(n), 64'(128*H));
    chk("R6 fields kept", 64'(rd_data), 64'h40A0_9000);

    write_cmd(32'hC0C0_9000);
    wait_done(n);
    chk("R2 write frame PHY6", cap, 64'hFFFF_FFFF_5302_9000);

    phy_val = 16'hA5C3;
    write_cmd(32'h80C1_0000);
    repeat (40) @(negedge clk);
    write_cmd(32'hC3FF_1234);   // R7: must be dropped
    wait_done(n);
    chk("R4 read data", 64'(rd_data), 64'h00C1_A5C3);
    chk("R7 write during frame dropped", 64'(n + 42), 64'(128*H));
    repeat (20) @(negedge clk);
    chk("R7 no second frame", {63'h0, mdc}, 64'h0);
    chk("R3 read frame header", cap[63:18], exp_frame(32'h80C1_0000) >> 18);

    write_cmd(32'h1234_5678);
    repeat (20) @(negedge clk);
    chk("R1 stored without request", 64'(rd_data), 64'h1234_5678);
    chk("R1 no frame", {62'h0, mdc, mdio_oe}, 64'h0);

    phy_val = 16'h0001;
    write_cmd(32'h83FF_0000);
    wait_done(n);
    chk("R4 read single bit", 64'(rd_data), 64'h03FF_0001);
    chk("R6 read busy length", 64'(n), 64'(128*H));

    phy_val = 16'h8000;
    write_cmd(32'h8021_FFFF);
    wait_done(n);
    chk("R4 read msb", 64'(rd_data), 64'h0021_8000);
    write_cmd(32'hC000_0F0F);   // R1: right after completion
    wait_done(n);
    chk("R1 back-to-back accepted", 64'(n), 64'(128*H));
    chk("R2 zero address frame", cap, 64'hFFFF_FFFF_5002_0F0F);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule